// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Byte Loader

This block accepts configuration bytes from a host over a parallel bus and sends them out as a serial bit stream with its own configuration clock. The host qualifies a write with three chip selects and a write strobe. The byte is taken when the strobe ends. It is first held in an input register and then moved into a shift register. The shift register sends it out least-significant bit first, one bit per configuration-clock period.

Because there are two storage levels, the host can load the next byte while the current one is still shifting. An active-high ready output tells the host when the input register is free. The busy time is short when the shift register is empty. It is long when the shift register still holds a byte that must finish first. Successive bytes leave back to back, with no gap in the serial stream.

All host inputs are asynchronous to the system clock and are synchronized inside the block. The configuration clock is a divided copy of the system clock from a free-running counter. It is only passed to the output while the shift register holds data.

Top module: `cfg_byte_loader`

## Requirements
- R1: A write is qualified only while `sel_a_n`=0, `sel_b_n`=0, `sel_c`=1 and `wr_n`=0 all hold together; a strobe with any select inactive captures nothing, leaves `ready` high and starts no serial output.
- R2: The byte captured is the value on `din` during the last sampled cycle of the qualified strobe; `din` may change at the same moment the strobe ends (zero hold) without corrupting the byte.
- R3: After a qualified strobe ends, `ready` goes low no later than the third falling system-clock edge and no earlier than the first.
- R4: `ready` returns high in the cycle the input register moves into the shift register, and that byte's first bit is driven at once; the host may begin the next write immediately.
- R5: `cclk` has a period of CLK_DIV system clocks, low for the first half and high for the second half. It toggles only while the shift register holds data. While idle, `cclk` is low and `dout` is high.
- R6: Bits leave least-significant first. Each bit changes only at the start of a period, while `cclk` is low, and is stable across the rising edge of `cclk`.
- R7: When the next byte is waiting in the input register, its bit 0 follows bit 7 of the previous byte in the very next period. In a burst, `cclk` rises every CLK_DIV cycles without a gap.
- R8: When the shift register is empty, busy lasts at least 1 and at most CLK_DIV system clocks. The byte moves down at the next period boundary.
- R9: When the shift register is still sending an earlier byte, busy lasts until that byte's last bit period ends, which is more than 5*CLK_DIV system clocks in a back-to-back burst.
- R10: After synchronous reset, `ready`=1, `cclk`=0 and `dout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_a_n | input | 1 | Chip select, active low (asynchronous) |
| sel_b_n | input | 1 | Chip select, active low (asynchronous) |
| sel_c | input | 1 | Chip select, active high (asynchronous) |
| wr_n | input | 1 | Write strobe, active low (asynchronous) |
| din | input | DATA_W | Parallel byte from the host |
| ready | output | 1 | High when a new byte may be written, low while busy |
| cclk | output | 1 | Configuration clock, gated by shifter occupancy |
| dout | output | 1 | Serial data, LSB first, high when idle |

## Verification
Two things can land on the same system-clock cycle. One is the capture pulse that ends a host write. The other is the period boundary at which the shift register either takes the input register or sends its last bit. The bench provokes this coincidence by repeating a single write after a delay that steps through every phase of the free-running divider. Back-to-back bursts make the handoff coincide with the end of the eighth bit. Each case is judged by a behavioural reference model compared on every clock for `ready`, `cclk` and `dout`. The bench also decodes the serial stream and checks the bit order, the clock spacing and the busy durations.

// File: rtl/cfg_loader_pkg.sv
// Shared types for the configuration byte loader.
// Assumes: host control lines are grouped into one packed word.
package cfg_loader_pkg;

    typedef struct packed {
        logic sel_a_n;
        logic sel_b_n;
        logic sel_c;
        logic wr_n;
    } host_ctl_t;

    // Inactive level of every host control line, used as reset value.
    localparam host_ctl_t CTL_IDLE = '{sel_a_n: 1'b1, sel_b_n: 1'b1, sel_c: 1'b0, wr_n: 1'b1};

    // True when all selects and the strobe are active together.
    function automatic logic ctl_active(input host_ctl_t c);
        return ~c.sel_a_n & ~c.sel_b_n & c.sel_c & ~c.wr_n;
    endfunction

endpackage

// File: rtl/cfg_host_sync.sv
// Synchronizes asynchronous host control and data lines to clk and
// produces a one-cycle capture pulse when the write qualification ends.
// Assumes: data and controls pass through equal-depth synchronizers, so
// the captured byte is the one seen in the last qualified sample.
module cfg_host_sync
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  host_ctl_t         ctl_raw,
    input  logic [DATA_W-1:0] din_raw,
    output logic              cap_pulse,
    output logic [DATA_W-1:0] cap_data
);
    localparam int LAST = SYNC_STAGES - 1;

    host_ctl_t         ctl_s [SYNC_STAGES];
    logic [DATA_W-1:0] dat_s [SYNC_STAGES];
    logic              qual_now;
    logic              qual_d;
    logic [DATA_W-1:0] dat_d;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First synchronizer flop, fed by the raw host lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_s[g] <= CTL_IDLE;
                    dat_s[g] <= '0;
                end else begin
                    ctl_s[g] <= ctl_raw;
                    dat_s[g] <= din_raw;
                end
            end
        end else begin : g_next
            // Later synchronizer flops, fed by the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ctl_s[g] <= CTL_IDLE;
                    dat_s[g] <= '0;
                end else begin
                    ctl_s[g] <= ctl_s[g-1];
                    dat_s[g] <= dat_s[g-1];
                end
            end
        end
    end

    // Write qualification seen at the synchronizer output.
    always_comb qual_now = ctl_active(ctl_s[LAST]);

    // One-cycle delay of the qualification and its matching data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_d <= 1'b0;
            dat_d  <= '0;
        end else begin
            qual_d <= qual_now;
            dat_d  <= dat_s[LAST];
        end
    end

    // Falling edge of the qualification: capture the last qualified byte.
    always_comb begin
        cap_pulse = qual_d & ~qual_now;
        cap_data  = dat_d;
    end

endmodule

// File: rtl/cfg_cclk_gen.sv
// Free-running divide-by-CLK_DIV timing generator. Marks the last cycle
// of every period and reports whether the current cycle is in the high
// half of the configuration clock.
// Assumes: CLK_DIV is even and at least 2.
module cfg_cclk_gen #(
    parameter int CLK_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic period_end,
    output logic high_half
);
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int HALF  = CLK_DIV / 2;

    logic [CNT_W-1:0] cnt;

    // Period counter, wraps at CLK_DIV-1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == CNT_W'(CLK_DIV - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Phase decode for the handoff logic and the clock output.
    always_comb begin
        period_end = (cnt == CNT_W'(CLK_DIV - 1));
        high_half  = (cnt >= CNT_W'(HALF));
    end

endmodule

// File: rtl/cfg_two_level_buf.sv
// Input register plus shift register. A captured byte waits in the input
// register until a period boundary finds the shifter empty or sending its
// last bit, then moves down and shifts out LSB first, one bit per period.
// Assumes: the host waits for the input register to free before writing;
// a capture into a full input register replaces the held byte.
module cfg_two_level_buf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pulse,
    input  logic [DATA_W-1:0] cap_data,
    input  logic              period_end,
    output logic              in_full,
    output logic              sh_full,
    output logic [$clog2(DATA_W)-1:0] bit_idx,
    output logic              sh_lsb
);
    localparam int BIT_W = $clog2(DATA_W);

    logic [DATA_W-1:0] in_reg;
    logic [DATA_W-1:0] sh_reg;
    logic              last_bit;
    logic              load_sh;

    // Handoff decision at a period boundary.
    always_comb begin
        last_bit = (bit_idx == BIT_W'(DATA_W - 1));
        load_sh  = period_end & in_full & (~sh_full | last_bit);
        sh_lsb   = sh_reg[0];
    end

    // First-level holding register, filled by capture, emptied by handoff.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full <= 1'b0;
            in_reg  <= '0;
        end else if (cap_pulse) begin
            in_full <= 1'b1;
            in_reg  <= cap_data;
        end else if (load_sh) begin
            in_full <= 1'b0;
        end
    end

    // Second-level shifter: shift, reload or drain at each period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_full <= 1'b0;
            sh_reg  <= '0;
            bit_idx <= '0;
        end else if (period_end) begin
            if (sh_full && !last_bit) begin
                sh_reg  <= sh_reg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end else if (in_full) begin
                sh_full <= 1'b1;
                sh_reg  <= in_reg;
                bit_idx <= '0;
            end else begin
                sh_full <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/cfg_byte_loader.sv
// Top of the configuration byte loader: host synchronizer, timing
// generator and two-level buffer. Drives ready, the gated configuration
// clock and the serial data line.
// Assumes: all host inputs are asynchronous to clk.
module cfg_byte_loader
    import cfg_loader_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CLK_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              ready,
    output logic              cclk,
    output logic              dout
);
    localparam int BIT_W = $clog2(DATA_W);

    host_ctl_t         ctl_raw;
    logic              cap_pulse;
    logic [DATA_W-1:0] cap_data;
    logic              period_end;
    logic              high_half;
    logic              in_full;
    logic              sh_full;
    logic [BIT_W-1:0]  bit_idx;
    logic              sh_lsb;

    // Group the host control lines.
    always_comb ctl_raw = '{sel_a_n: sel_a_n, sel_b_n: sel_b_n, sel_c: sel_c, wr_n: wr_n};

    cfg_host_sync #(
        .DATA_W     (DATA_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_raw  (ctl_raw),
        .din_raw  (din),
        .cap_pulse(cap_pulse),
        .cap_data (cap_data)
    );

    cfg_cclk_gen #(
        .CLK_DIV(CLK_DIV)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .period_end(period_end),
        .high_half (high_half)
    );

    cfg_two_level_buf #(
        .DATA_W(DATA_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pulse (cap_pulse),
        .cap_data  (cap_data),
        .period_end(period_end),
        .in_full   (in_full),
        .sh_full   (sh_full),
        .bit_idx   (bit_idx),
        .sh_lsb    (sh_lsb)
    );

    // Output decode: ready, gated clock, serial line idling high.
    always_comb begin
        ready = ~in_full;
        cclk  = sh_full & high_half;
        dout  = sh_full ? sh_lsb : 1'b1;
    end

endmodule

// File: rtl/cfg_loader_checker.sv
// Property checker for cfg_byte_loader, attached by bind below.
// Assumes: connected to the top's ports and internal handoff signals.
module cfg_loader_checker #(
    parameter int DATA_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ready,
    input logic                      cclk,
    input logic                      dout,
    input logic                      cap_pulse,
    input logic                      sh_full,
    input logic                      period_end,
    input logic [$clog2(DATA_W)-1:0] bit_idx
);

    // R3: a capture makes the block busy on the next cycle.
    p_busy_after_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !ready);

    // R4: ready rises only as a fresh byte lands in the shifter at bit 0.
    p_ready_on_handoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (sh_full && bit_idx == '0));

    // R5: idle line is high with the clock parked low.
    p_idle_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sh_full |-> (dout && !cclk));

    // R5: every period starts with the clock low.
    p_period_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> !cclk);

    // R6: data is stable across each rising configuration-clock edge.
    p_bit_stable_at_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk) |-> $stable(dout));

    // R6: data moves only while the configuration clock is low.
    p_bit_moves_when_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> !cclk);

endmodule

bind cfg_byte_loader cfg_loader_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .cclk      (cclk),
    .dout      (dout),
    .cap_pulse (cap_pulse),
    .sh_full   (sh_full),
    .period_end(period_end),
    .bit_idx   (bit_idx)
);

// File: tb/tb_cfg_byte_loader.sv
module tb_cfg_byte_loader;
    localparam int DATA_W  = 8;
    localparam int CLK_DIV = 8;
    localparam int WD_LIM  = 150000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0, wr_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic              ready, cclk, dout;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    cfg_byte_loader #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
        .sel_c(sel_c), .wr_n(wr_n), .din(din),
        .ready(ready), .cclk(cclk), .dout(dout)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int                m_cnt = 0;
    bit                m_in_full = 0, m_sh_full = 0;
    logic [DATA_W-1:0] m_in_reg = '0, m_sh_reg = '0;
    int                m_bits = 0;
    bit                q_hist [3];
    logic [DATA_W-1:0] d_hist [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_in_full = 0; m_sh_full = 0; m_bits = 0;
            m_in_reg = '0; m_sh_reg = '0;
            for (int i = 0; i < 3; i++) begin q_hist[i] = 0; d_hist[i] = '0; end
        end else begin
            bit cap, moved;
            cap = q_hist[2] && !q_hist[1];
            moved = 0;
            if (m_cnt == CLK_DIV - 1) begin
                if (m_sh_full && m_bits < DATA_W - 1) begin
                    m_sh_reg = m_sh_reg >> 1; m_bits++;
                end else if (m_in_full) begin
                    m_sh_reg = m_in_reg; m_bits = 0; m_sh_full = 1; moved = 1;
                end else begin
                    m_sh_full = 0;
                end
            end
            if (cap) begin m_in_full = 1; m_in_reg = d_hist[2]; end
            else if (moved) m_in_full = 0;
            m_cnt = (m_cnt + 1) % CLK_DIV;
            q_hist[2] = q_hist[1]; q_hist[1] = q_hist[0];
            q_hist[0] = !sel_a_n && !sel_b_n && sel_c && !wr_n;
            d_hist[2] = d_hist[1]; d_hist[1] = d_hist[0]; d_hist[0] = din;
        end
    end

    // Per-cycle comparison against the model (R4 R5 R6 outputs).
    always @(negedge clk) begin
        bit e_rdy, e_ck, e_do;
        e_rdy = !m_in_full;
        e_ck  = m_sh_full && (m_cnt >= CLK_DIV / 2);
        e_do  = m_sh_full ? m_sh_reg[0] : 1'b1;
        check(ready == e_rdy && cclk == e_ck && dout == e_do, "R4 R5 R6 cycle model",
              {ready, cclk, dout}, {e_rdy, e_ck, e_do});
    end

    // ---------------- serial stream decoder ----------------
    bit   exp_bits[$];
    logic prev_cclk = 1'b0;
    int   hi_len = 0;
    int   rise_cnt = 0, first_rise = -1, last_rise = -1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cclk && !prev_cclk) begin
                if (exp_bits.size() == 0) begin
                    check(0, "R6 unexpected bit", dout, 1);
                end else begin
                    bit eb;
                    eb = exp_bits.pop_front();
                    check(dout == eb, "R6 R2 serial bit", dout, eb);
                end
                rise_cnt++;
                if (first_rise < 0) first_rise = cyc;
                last_rise = cyc;
            end
            if (cclk) hi_len++;
            if (!cclk && prev_cclk) begin
                check(hi_len == CLK_DIV / 2, "R5 cclk high time", hi_len, CLK_DIV / 2);
                hi_len = 0;
            end
        end
        prev_cclk = cclk;
    end

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIM) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WD_LIM);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- host stimulus ----------------
    // mode 0: qualified; 1: sel_a_n held high; 2: sel_c held low.
    task automatic host_write(input logic [DATA_W-1:0] b, input int mode, output int busy);
        int lat;
        @(negedge clk);
        sel_a_n = (mode == 1); sel_b_n = 1'b0; sel_c = (mode != 2);
        din = b; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1; din = ~b; sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
        if (mode == 0)
            for (int i = 0; i < DATA_W; i++) exp_bits.push_back(b[i]);
        busy = 0;
        if (mode != 0) begin
            bit stayed;
            stayed = 1;
            repeat (12) begin
                @(negedge clk);
                if (!ready || cclk) stayed = 0;
            end
            check(stayed, "R1 unqualified strobe ignored", stayed, 1);
        end else begin
            lat = 0;
            while (ready && lat < 10) begin @(negedge clk); lat++; end
            check(lat >= 1 && lat <= 3, "R3 busy latency", lat, 3);
            while (!ready) begin @(negedge clk); busy++; end
        end
    endtask

    task automatic wait_idle();
        repeat (12 * CLK_DIV) @(negedge clk);
    endtask

    initial begin
        int busy;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1, "R10 reset ready", ready, 1);
        check(cclk == 1'b0, "R10 reset cclk", cclk, 0);
        check(dout == 1'b1, "R10 reset dout", dout, 1);

        // R1: strobes lacking a select
        host_write(8'h5A, 1, busy);
        host_write(8'hC3, 2, busy);

        // R8: single byte into empty converter
        host_write(8'hA5, 0, busy);
        check(busy >= 1 && busy <= CLK_DIV, "R8 short busy", busy, CLK_DIV);
        wait_idle();
        check(exp_bits.size() == 0, "R2 byte fully sent", exp_bits.size(), 0);

        // Phase sweep: capture lands on every divider phase (R8, R4)
        for (int ph = 0; ph < CLK_DIV; ph++) begin
            repeat (ph) @(negedge clk);
            host_write(DATA_W'(8'h3C ^ (ph * 17)), 0, busy);
            check(busy >= 1 && busy <= CLK_DIV, "R8 short busy sweep", busy, CLK_DIV);
            wait_idle();
        end
        check(exp_bits.size() == 0, "R2 sweep bytes sent", exp_bits.size(), 0);

        // Burst: back-to-back bytes (R7, R9)
        rise_cnt = 0; first_rise = -1; last_rise = -1;
        for (int k = 0; k < 4; k++) begin
            while (!ready) @(negedge clk);
            host_write(DATA_W'(8'h81 + k * 8'h26), 0, busy);
            if (k == 1)
                check(busy > 5 * CLK_DIV, "R9 long busy", busy, 5 * CLK_DIV);
        end
        wait_idle();
        check(rise_cnt == 4 * DATA_W, "R7 burst bit count", rise_cnt, 4 * DATA_W);
        check(last_rise - first_rise == (4 * DATA_W - 1) * CLK_DIV, "R7 gapless burst",
              last_rise - first_rise, (4 * DATA_W - 1) * CLK_DIV);
        check(exp_bits.size() == 0, "R2 burst bytes sent", exp_bits.size(), 0);
        check(cclk == 1'b0 && dout == 1'b1, "R5 idle after burst", {cclk, dout}, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule